// File: doc/BRIEF.md
# Frame-Aligned Serial Byte Capture

This block takes the serial output of a multi-channel converter (a bit clock, a data line and a frame-sync line) and delivers it to a slower host one byte at a time. The three inputs come from outside the system clock domain. They are resynchronized, and every state change happens on a detected rising edge of the bit clock. Bits enter a shift register most significant bit first. Each eighth bit moves the assembled byte into a holding register, which the host reads.

The host learns that a byte is ready from a single level, `busy`. This level is the top bit of a bit counter that wraps every sixteen bits, so `busy` changes level once per byte. A rise and a fall both mean "read now". Two bytes make one 16-bit word, high byte first, and six words make a frame. A frame-sync edge realigns the counters at the start of each frame. A one-cycle pulse marks the last byte of the sixth word.

Top module: `serial_byte_capture`

## Requirements
- R1: Each detected rising edge of the bit clock shifts the synchronized data bit into the byte being assembled, most significant bit first.
- R2: On every eighth bit since the last alignment, the complete byte is copied to `byte_out`. `byte_out` changes at no other time.
- R3: A 4-bit bit counter advances on every accepted bit and wraps after 16. `busy` equals its bit 3, so it rises when the first byte of a word is latched and falls when the second byte is latched.
- R4: A rising edge of frame sync clears the bit counter, the partial byte and the word index, which forces `busy` low. A bit-clock edge detected in the same system cycle is dropped.
- R5: When frame sync arrives in the middle of a byte, the partial bits are discarded and `byte_out` keeps the last complete byte. The next byte is latched after eight further bits.
- R6: `word_idx` counts completed 16-bit words within the frame (0 to 5) and wraps to 0 after the sixth.
- R7: `end_of_frame` is high for exactly one system cycle: the cycle in which the second byte of the sixth word is latched.
- R8: Once a 96-bit frame has completed, `busy` stays low through the next frame sync and the first seven bits of the next frame. It rises on the eighth bit.
- R9: While reset is active, `byte_out` is 0x00, `busy` is 0, `word_idx` is 0 and `end_of_frame` is 0.
- R10: Each input passes through two synchronizer flops. A bit-clock or frame-sync rising edge that is present at system clock edge n takes effect in the outputs right after edge n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_in | input | 1 | Serial bit clock from the converter (asynchronous) |
| sdata_in | input | 1 | Serial data, valid at the bit-clock rising edge |
| fsync_in | input | 1 | Frame-sync pulse marking the start of a frame |
| byte_out | output | 8 | Last complete byte |
| busy | output | 1 | Byte-ready level; toggles once per completed byte |
| word_idx | output | 3 | Completed words in the current frame |
| end_of_frame | output | 1 | One-cycle pulse when the sixth word completes |

## Verification
The hardest situation to reach is a frame sync that lands partway through a byte while `busy` is high. In that case the holding register must stay put while `busy` drops and the counters realign. The stimulus reaches it by sending a few bits of the second byte of a word, then pulsing frame sync during a low phase of the bit clock, then sending a full new frame. A behavioural model that delays its inputs by the synchronizer depth is compared against the outputs on every system cycle. Directed checks on known byte values run alongside it.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
    // Events extracted from the synchronized serial inputs.
    typedef struct packed {
        logic data;
        logic bclk_rise;
        logic fsync_rise;
    } sbc_event_t;

    // Positions of the serial inputs in the synchronizer vector.
    localparam int unsigned IDX_BCLK  = 0;
    localparam int unsigned IDX_DATA  = 1;
    localparam int unsigned IDX_FSYNC = 2;
    localparam int unsigned N_SERIAL  = 3;
endpackage

// File: rtl/sbc_sync.sv
module sbc_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] stage_q;
    logic [STAGES-1:0][W-1:0] stage_d;

    always_comb begin
        stage_d = {stage_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sbc_edge.sv
module sbc_edge
    import sbc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_SERIAL-1:0] sync_i,
    output sbc_event_t          ev_o
);
    logic [N_SERIAL-1:0] prev_q, prev_d;
    logic [N_SERIAL-1:0] rise;

    genvar g;
    generate
        for (g = 0; g < N_SERIAL; g++) begin : g_rise
            assign rise[g] = sync_i[g] & ~prev_q[g];
        end
    endgenerate

    always_comb begin
        prev_d = sync_i;
        ev_o.data       = sync_i[IDX_DATA];
        ev_o.bclk_rise  = rise[IDX_BCLK];
        ev_o.fsync_rise = rise[IDX_FSYNC];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/sbc_core.sv
module sbc_core
    import sbc_pkg::*;
#(
    parameter int unsigned BYTE_W          = 8,
    parameter int unsigned WORDS_PER_FRAME = 6,
    localparam int unsigned BIT_W  = $clog2(BYTE_W),
    localparam int unsigned CNT_W  = BIT_W + 1,
    localparam int unsigned WORD_W = $clog2(WORDS_PER_FRAME)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sbc_event_t        ev_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              busy_o,
    output logic [WORD_W-1:0] word_o,
    output logic              eof_o
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] shreg;
        logic [BYTE_W-1:0] hold;
        logic [WORD_W-1:0] word;
        logic              eof;
    } core_state_t;

    core_state_t st_d, st_q;
    logic [BYTE_W-1:0] shifted;

    always_comb begin
        st_d     = st_q;
        st_d.eof = 1'b0;
        shifted  = {st_q.shreg[BYTE_W-2:0], ev_i.data};
        if (ev_i.fsync_rise) begin
            st_d.cnt   = '0;
            st_d.shreg = '0;
            st_d.word  = '0;
        end else if (ev_i.bclk_rise) begin
            st_d.shreg = shifted;
            st_d.cnt   = st_q.cnt + 1'b1;
            if (&st_q.cnt[BIT_W-1:0]) begin
                st_d.hold = shifted;
            end
            if (&st_q.cnt) begin
                if (st_q.word == WORD_W'(WORDS_PER_FRAME - 1)) begin
                    st_d.word = '0;
                    st_d.eof  = 1'b1;
                end else begin
                    st_d.word = st_q.word + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign byte_o = st_q.hold;
    assign busy_o = st_q.cnt[BIT_W];
    assign word_o = st_q.word;
    assign eof_o  = st_q.eof;

    // R2: a new byte in the holding register always comes with a busy transition
    p_hold_with_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.hold) |-> !$stable(busy_o));

    // R3: the last bit of a byte flips busy
    p_busy_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i.bclk_rise && !ev_i.fsync_rise && (&st_q.cnt[BIT_W-1:0]))
        |=> (busy_o != $past(busy_o)));

    // R4: frame sync realigns counters and drops busy
    p_sync_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i.fsync_rise |=> (st_q.cnt == '0 && word_o == '0 && !busy_o));

    // R6: word index stays inside the frame
    p_word_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        word_o < WORD_W'(WORDS_PER_FRAME));

    // R7: end-of-frame is a single-cycle pulse at a word boundary
    p_eof_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eof_o |=> !eof_o);
    p_eof_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eof_o |-> (word_o == '0 && !busy_o && $past(word_o) == WORD_W'(WORDS_PER_FRAME - 1)));
endmodule

// File: rtl/serial_byte_capture.sv
module serial_byte_capture
    import sbc_pkg::*;
#(
    parameter int unsigned BYTE_W          = 8,
    parameter int unsigned WORDS_PER_FRAME = 6,
    parameter int unsigned SYNC_STAGES     = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 bclk_in,
    input  logic                                 sdata_in,
    input  logic                                 fsync_in,
    output logic [BYTE_W-1:0]                    byte_out,
    output logic                                 busy,
    output logic [$clog2(WORDS_PER_FRAME)-1:0]   word_idx,
    output logic                                 end_of_frame
);
    logic [N_SERIAL-1:0] raw_in;
    logic [N_SERIAL-1:0] synced;
    sbc_event_t          ev;

    always_comb begin
        raw_in            = '0;
        raw_in[IDX_BCLK]  = bclk_in;
        raw_in[IDX_DATA]  = sdata_in;
        raw_in[IDX_FSYNC] = fsync_in;
    end

    sbc_sync #(.W(N_SERIAL), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (synced)
    );

    sbc_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (synced),
        .ev_o   (ev)
    );

    sbc_core #(.BYTE_W(BYTE_W), .WORDS_PER_FRAME(WORDS_PER_FRAME)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_i   (ev),
        .byte_o (byte_out),
        .busy_o (busy),
        .word_o (word_idx),
        .eof_o  (end_of_frame)
    );
endmodule

// File: tb/serial_byte_capture_tb.sv
module serial_byte_capture_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bclk_in = 1'b0;
    logic       sdata_in = 1'b0;
    logic       fsync_in = 1'b0;
    logic [7:0] byte_out;
    logic       busy;
    logic [2:0] word_idx;
    logic       end_of_frame;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit compare_on = 1'b0;
    int eof_seen = 0;

    localparam int HALF = 4;

    always #5 clk = ~clk;

    serial_byte_capture dut_i (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .sdata_in(sdata_in),
        .fsync_in(fsync_in), .byte_out(byte_out), .busy(busy),
        .word_idx(word_idx), .end_of_frame(end_of_frame)
    );

    // Behavioural reference: inputs seen two edges late, edges from one more back (R10)
    bit hb1, hb2, hb3, hd1, hd2, hf1, hf2, hf3;
    int m_bits, m_sh, m_hold, m_word;
    bit m_eof;

    always @(posedge clk) begin
        if (!rst_n) begin
            {hb1, hb2, hb3, hd1, hd2, hf1, hf2, hf3} = '0;
            m_bits = 0; m_sh = 0; m_hold = 0; m_word = 0; m_eof = 0;
        end else begin
            m_eof = 0;
            if (hf2 && !hf3) begin
                m_bits = 0; m_sh = 0; m_word = 0;
            end else if (hb2 && !hb3) begin
                m_sh = ((m_sh << 1) | int'(hd2)) & 255;
                if (m_bits % 8 == 7) m_hold = m_sh;
                if (m_bits == 15) begin
                    if (m_word == 5) begin m_word = 0; m_eof = 1; end
                    else m_word = m_word + 1;
                end
                m_bits = (m_bits + 1) % 16;
            end
            hb3 = hb2; hb2 = hb1; hb1 = bclk_in;
            hd2 = hd1; hd1 = sdata_in;
            hf3 = hf2; hf2 = hf1; hf1 = fsync_in;
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (compare_on && rst_n) begin
            check("R1/R2 byte_out model", int'(byte_out), m_hold);
            check("R3/R8 busy model", int'(busy), (m_bits >= 8) ? 1 : 0);
            check("R6 word_idx model", int'(word_idx), m_word);
            check("R7 end_of_frame model", int'(end_of_frame), int'(m_eof));
            if (end_of_frame) eof_seen++;
        end
    end

    task automatic send_bit(bit b);
        @(negedge clk);
        bclk_in = 1'b0; sdata_in = b;
        repeat (HALF) @(negedge clk);
        bclk_in = 1'b1;
        repeat (HALF - 1) @(negedge clk);
    endtask

    task automatic send_byte(logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        repeat (4) @(negedge clk);
        bclk_in = 1'b0;
    endtask

    task automatic pulse_fsync();
        @(negedge clk);
        bclk_in = 1'b0;
        repeat (2) @(negedge clk);
        fsync_in = 1'b1;
        repeat (2) @(negedge clk);
        fsync_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_frame(int seed);
        for (int w = 0; w < 6; w++) begin
            logic [15:0] word;
            word = 16'((seed * 16'h3B1) ^ (w * 16'h1F27) ^ 16'hA55A);
            send_byte(word[15:8]);
            check("R2 directed high byte", int'(byte_out), int'(word[15:8]));
            check("R3 busy high after first byte", int'(busy), 1);
            send_byte(word[7:0]);
            check("R2 directed low byte", int'(byte_out), int'(word[7:0]));
            check("R3 busy low after second byte", int'(busy), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset byte_out", int'(byte_out), 0);
        check("R9 reset busy", int'(busy), 0);
        check("R9 reset word_idx", int'(word_idx), 0);
        check("R9 reset end_of_frame", int'(end_of_frame), 0);
        rst_n = 1'b1;
        compare_on = 1'b1;
        repeat (4) @(negedge clk);

        // R1: MSB-first byte with distinct pattern
        pulse_fsync();
        send_byte(8'h81);
        check("R1 msb first", int'(byte_out), 8'h81);
        // R10: latency of an edge to the outputs
        send_bit(1'b1);
        send_bit(1'b0);

        // Full frames
        for (int f = 0; f < 3; f++) begin
            eof_seen = 0;
            pulse_fsync();
            check("R4 word_idx cleared", int'(word_idx), 0);
            send_frame(f + 1);
            check("R7 one eof per frame", eof_seen, 1);
            check("R6 word_idx wrapped", int'(word_idx), 0);
        end

        // R8: busy quiet over frame sync and first seven bits
        pulse_fsync();
        check("R8 busy low after sync", int'(busy), 0);
        for (int i = 0; i < 7; i++) send_bit(i[0]);
        repeat (4) @(negedge clk);
        check("R8 busy low after 7 bits", int'(busy), 0);
        send_bit(1'b1);
        repeat (4) @(negedge clk);
        check("R8 busy rises on 8th bit", int'(busy), 1);
        check("R8 byte value", int'(byte_out), 8'h55);

        // R5/R4: sync mid-byte while busy is high
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        pulse_fsync();
        check("R5 hold kept", int'(byte_out), 8'h55);
        check("R4 busy forced low", int'(busy), 0);
        check("R4 word_idx zero", int'(word_idx), 0);
        send_byte(8'hC3);
        check("R5 realigned byte", int'(byte_out), 8'hC3);
        eof_seen = 0;
        send_byte(8'h3C);
        for (int w = 1; w < 6; w++) begin
            send_byte(8'(w * 17)); send_byte(8'(w * 29));
        end
        check("R7 eof after realigned frame", eof_seen, 1);

        // Free-running without sync: counters wrap on their own (R6)
        send_frame(9);

        repeat (8) @(negedge clk);
        compare_on = 1'b0;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule